// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational word-wide operator. It takes two operands, a carry input, a four-bit operation code and two serial fill bits. It returns one result word and a carry flag. The bits of the word are built from identical slices. Each slice forms four candidates:

- a full-adder sum on a rippling carry chain;
- a bitwise logic result;
- the bit one place above it, for a shift toward the LSB;
- the bit one place below it, for a shift toward the MSB.

A four-way selector in each slice, steered by the upper two code bits, keeps one of the four candidates. The lower two code bits and the carry input refine the arithmetic and logic functions.

The shifts take their end bits from two fill inputs, one for each direction. The surrounding logic chooses the shift flavour by how it drives those fill inputs:

- a constant fill gives a logical shift;
- the operand's own top bit gives an arithmetic (sign-keeping) right shift;
- the bit falling out at the other end gives a rotate.

Top module: `arith_logic_shifter`

## Requirements
- R1: `opSel[3:2]` picks the unit: 00 arithmetic, 01 logic, 10 shift toward LSB, 11 shift toward MSB.
- R2: With `opSel[3:2]`=10, `result[i]` equals `opA[i+1]` for i below W-1, and `result[W-1]` equals `fillHigh`.
- R3: With `opSel[3:2]`=11, `result[i]` equals `opA[i-1]` for i above 0, and `result[0]` equals `fillLow`.
- R4: With `opSel[3:2]`=01, `opSel[1:0]` selects the logic function: 00 AND, 01 OR, 10 XOR, 11 NOT of `opA`. `carryIn` has no effect on these.
- R5: With `opSel[3:2]`=00 and `carryIn`=0, `opSel[1:0]` gives the following, each modulo 2^W:
  - 00: A+B
  - 01: A+~B
  - 10: A-1
  - 11: A
- R6: With `opSel[3:2]`=00 and `carryIn`=1, `opSel[1:0]` gives the following, each modulo 2^W:
  - 00: A+B+1
  - 01: A-B
  - 10: A+1
  - 11: A
- R7: For arithmetic codes, `carryOut` is bit W of the unbounded sum that R5 and R6 use:
  - A-1 is formed as A plus all ones.
  - A+1 is formed as A+0+1.
  - A is formed as A+0+0.
  - For every non-arithmetic code, `carryOut` is 0.
- R8: Tying `fillHigh` to `opA[W-1]` gives an arithmetic right shift that keeps the sign bit. Tying `fillHigh` to `opA[0]`, or `fillLow` to `opA[W-1]`, gives a rotate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W | First operand; also the word that is shifted |
| opB | input | W | Second operand |
| carryIn | input | 1 | Carry into the lowest slice; refines arithmetic codes |
| opSel | input | 4 | Operation code: [3:2] unit, [1:0] function |
| fillHigh | input | 1 | Bit entering the MSB on a shift toward LSB |
| fillLow | input | 1 | Bit entering the LSB on a shift toward MSB |
| result | output | W | Selected result word |
| carryOut | output | 1 | Carry from the top slice for arithmetic codes, else 0 |

## Verification
The arithmetic path is tested with operand pairs that wrap at the word boundary and pairs that do not. Examples are all-ones plus one, subtraction in both operand orders, and decrement of zero. These separate a correct carry chain and carry flag from one that drops or inverts the top carry.

The logic functions use the pair 0xAA/0xCC, which covers all four input combinations in every function. Each logic code is tried with the carry input both low and high.

Shifts use asymmetric words with each fill value, and with fills tied for sign-keeping and rotating. These expose swapped neighbours, swapped fill inputs and a fill applied at the wrong end.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'b00,
    UNIT_LOGIC = 2'b01,
    UNIT_SHR   = 2'b10,
    UNIT_SHL   = 2'b11
  } unitSel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'b00,
    LOG_OR  = 2'b01,
    LOG_XOR = 2'b10,
    LOG_NOT = 2'b11
  } logicOp_e;

  // how the B input of each full adder is formed
  typedef enum logic [1:0] {
    BSRC_PASS   = 2'b00,
    BSRC_INVERT = 2'b01,
    BSRC_ONES   = 2'b10,
    BSRC_ZERO   = 2'b11
  } bSrc_e;

  typedef struct packed {
    unitSel_e unit;
    logicOp_e logicOp;
    bSrc_e    bSrc;
    logic     adderCin;
    logic     carryKeep;
  } ctrlStrobes_t;

endpackage

// File: rtl/alsu_ctrl.sv
module alsu_ctrl
  import alsu_pkg::*;
(
  input  logic [3:0]   opSel,
  input  logic         carryIn,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.unit      = unitSel_e'(opSel[3:2]);
    strobes.logicOp   = logicOp_e'(opSel[1:0]);
    strobes.carryKeep = (opSel[3:2] == UNIT_ARITH);
    strobes.adderCin  = carryIn;
    strobes.bSrc      = BSRC_PASS;
    unique case (opSel[1:0])
      2'b00: strobes.bSrc = BSRC_PASS;
      2'b01: strobes.bSrc = BSRC_INVERT;
      2'b10: strobes.bSrc = carryIn ? BSRC_ZERO : BSRC_ONES;  // inc / dec
      2'b11: begin                                            // transfer
        strobes.bSrc     = BSRC_ZERO;
        strobes.adderCin = 1'b0;
      end
      default: strobes.bSrc = BSRC_PASS;
    endcase
  end

endmodule

// File: rtl/alsu_slice.sv
module alsu_slice
  import alsu_pkg::*;
(
  input  logic     aBit,
  input  logic     bBit,
  input  logic     aUpper,
  input  logic     aLower,
  input  logic     cIn,
  input  unitSel_e unit,
  input  logicOp_e logicOp,
  input  bSrc_e    bSrc,
  output logic     resBit,
  output logic     cOut
);

  logic bEff;
  logic sumBit;
  logic logicBit;

  always_comb begin
    unique case (bSrc)
      BSRC_PASS:   bEff = bBit;
      BSRC_INVERT: bEff = ~bBit;
      BSRC_ONES:   bEff = 1'b1;
      BSRC_ZERO:   bEff = 1'b0;
      default:     bEff = bBit;
    endcase
  end

  assign sumBit = aBit ^ bEff ^ cIn;
  assign cOut   = (aBit & bEff) | (cIn & (aBit ^ bEff));

  always_comb begin
    unique case (logicOp)
      LOG_AND: logicBit = aBit & bBit;
      LOG_OR:  logicBit = aBit | bBit;
      LOG_XOR: logicBit = aBit ^ bBit;
      LOG_NOT: logicBit = ~aBit;
      default: logicBit = aBit & bBit;
    endcase
  end

  always_comb begin
    unique case (unit)
      UNIT_ARITH: resBit = sumBit;
      UNIT_LOGIC: resBit = logicBit;
      UNIT_SHR:   resBit = aUpper;
      UNIT_SHL:   resBit = aLower;
      default:    resBit = sumBit;
    endcase
  end

endmodule

// File: rtl/alsu_datapath.sv
module alsu_datapath
  import alsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         fillHigh,
  input  logic         fillLow,
  input  ctrlStrobes_t strobes,
  output logic [W-1:0] result,
  output logic         carryOut
);

  localparam int EXT_W = W + 2;

  logic [W:0]       carryChain;
  logic [EXT_W-1:0] aExt;

  assign carryChain[0] = strobes.adderCin;
  assign aExt          = {fillHigh, opA, fillLow};

  for (genvar i = 0; i < W; i++) begin : g_slice
    alsu_slice u_slice (
      .aBit    (opA[i]),
      .bBit    (opB[i]),
      .aUpper  (aExt[i+2]),
      .aLower  (aExt[i]),
      .cIn     (carryChain[i]),
      .unit    (strobes.unit),
      .logicOp (strobes.logicOp),
      .bSrc    (strobes.bSrc),
      .resBit  (result[i]),
      .cOut    (carryChain[i+1])
    );
  end

  assign carryOut = carryChain[W] & strobes.carryKeep;

endmodule

// File: rtl/arith_logic_shifter.sv
module arith_logic_shifter
  import alsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  logic [3:0]   opSel,
  input  logic         fillHigh,
  input  logic         fillLow,
  output logic [W-1:0] result,
  output logic         carryOut
);

  ctrlStrobes_t strobes;

  alsu_ctrl u_ctrl (
    .opSel   (opSel),
    .carryIn (carryIn),
    .strobes (strobes)
  );

  alsu_datapath #(.W(W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .fillHigh (fillHigh),
    .fillLow  (fillLow),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/alsu_checker.sv
module alsu_checker #(
  parameter int W = 8
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         carryIn,
  input logic [3:0]   opSel,
  input logic         fillHigh,
  input logic         fillLow,
  input logic [W-1:0] result,
  input logic         carryOut
);

  always_comb begin
    if (opSel[3:2] != 2'b00)
      a_r7_no_carry_outside_arith: assert (carryOut == 1'b0);
    if (opSel[3:2] == 2'b10)
      a_r2_shr_fill_msb: assert (result[W-1] == fillHigh);
    if (opSel[3:2] == 2'b11)
      a_r3_shl_fill_lsb: assert (result[0] == fillLow);
    if (opSel == 4'b0011)
      a_r5_transfer_keeps_a: assert (result == opA);
    if (opSel == 4'b0100)
      a_r4_logic_and: assert (result == (opA & opB));
    if (opSel == 4'b0111)
      a_r4_logic_not: assert (result == ~opA);
  end

endmodule

bind arith_logic_shifter alsu_checker #(.W(W)) u_alsu_checker (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .opSel    (opSel),
  .fillHigh (fillHigh),
  .fillLow  (fillLow),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/arith_logic_shifter_bench.sv
module arith_logic_shifter_bench;

  localparam int W = 8;

  typedef struct {
    logic [W-1:0] res;
    logic         co;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [3:0]   opSel = 4'b0000;
  logic         fillHigh = 1'b0;
  logic         fillLow = 1'b0;
  logic [W-1:0] result;
  logic         carryOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  expItem_t scoreQ[$];

  always #4 clk = ~clk;  // 125 MHz

  arith_logic_shifter #(.W(W)) u_arith_logic_shifter (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .opSel    (opSel),
    .fillHigh (fillHigh),
    .fillLow  (fillLow),
    .result   (result),
    .carryOut (carryOut)
  );

  // reference model built from the requirement text
  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic ci, input logic [3:0] s,
                                input logic fh, input logic fl,
                                output logic [W-1:0] r, output logic co);
    logic [W:0] t;
    logic [W:0] ea;
    ea = {1'b0, a};
    t  = '0;
    co = 1'b0;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: t = ea + {1'b0, b} + (W+1)'(ci);
          2'b01: t = ea + {1'b0, ~b} + (W+1)'(ci);
          2'b10: t = ci ? ea + (W+1)'(1) : ea + {1'b0, {W{1'b1}}};
          default: t = ea;
        endcase
        r  = t[W-1:0];
        co = t[W];
      end
      2'b01: begin
        case (s[1:0])
          2'b00: r = a & b;
          2'b01: r = a | b;
          2'b10: r = a ^ b;
          default: r = ~a;
        endcase
      end
      2'b10: r = {fh, a[W-1:1]};
      default: r = {a[W-2:0], fl};
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input logic [3:0] s,
                       input logic fh, input logic fl, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    opA = a; opB = b; carryIn = ci; opSel = s; fillHigh = fh; fillLow = fl;
    model(a, b, ci, s, fh, fl, it.res, it.co);
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  // monitor: compare at the falling edge, well after inputs settle
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      expItem_t it;
      it = scoreQ.pop_front();
      testsRun++;
      if (result !== it.res || carryOut !== it.co) begin
        testsFailed++;
        $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                 it.tag, result, carryOut, it.res, it.co);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // state out of reset: all-zero inputs give a zero sum
    drive(8'h00, 8'h00, 0, 4'b0000, 0, 0, "R5 reset-state zero");
    // R1 unit select with the same operands across units
    drive(8'h5A, 8'h3C, 0, 4'b0000, 1, 1, "R1 unit arith");
    drive(8'h5A, 8'h3C, 0, 4'b0110, 1, 1, "R1 unit logic");
    drive(8'h5A, 8'h3C, 0, 4'b1000, 1, 1, "R1 unit shr");
    drive(8'h5A, 8'h3C, 0, 4'b1100, 1, 1, "R1 unit shl");
    // R5 carry in low
    drive(8'h35, 8'h4A, 0, 4'b0000, 0, 0, "R5 add");
    drive(8'h50, 8'h20, 0, 4'b0001, 0, 0, "R5 add complement");
    drive(8'h00, 8'h77, 0, 4'b0010, 0, 0, "R5 decrement zero");
    drive(8'h81, 8'h77, 0, 4'b0010, 0, 0, "R5 decrement");
    drive(8'hC3, 8'hFF, 0, 4'b0011, 0, 0, "R5 transfer");
    // R6 carry in high
    drive(8'hFF, 8'h00, 1, 4'b0000, 0, 0, "R6 add with carry wraps");
    drive(8'h50, 8'h20, 1, 4'b0001, 0, 0, "R6 subtract no borrow");
    drive(8'h20, 8'h50, 1, 4'b0001, 0, 0, "R6 subtract borrow");
    drive(8'hFF, 8'h12, 1, 4'b0010, 0, 0, "R6 increment wraps");
    drive(8'h3E, 8'h12, 1, 4'b0010, 0, 0, "R6 increment");
    drive(8'hC3, 8'hFF, 1, 4'b0011, 0, 0, "R6 transfer");
    // R7 carry flag
    drive(8'hF0, 8'h10, 0, 4'b0000, 0, 0, "R7 add carry out");
    drive(8'hFF, 8'hFF, 1, 4'b0100, 0, 0, "R7 no carry in logic");
    drive(8'hFF, 8'hFF, 1, 4'b1000, 1, 1, "R7 no carry in shift");
    // R4 logic, both carry-in values
    for (int k = 0; k < 8; k++)
      drive(8'hAA, 8'hCC, k[2], {2'b01, k[1:0]}, 0, 0, "R4 logic function");
    // R2 and R3 shifts with both fill values
    drive(8'hB4, 8'h00, 0, 4'b1000, 0, 1, "R2 shr fill 0");
    drive(8'hB4, 8'h00, 0, 4'b1000, 1, 0, "R2 shr fill 1");
    drive(8'h2D, 8'h00, 0, 4'b1100, 1, 0, "R3 shl fill 0");
    drive(8'h2D, 8'h00, 0, 4'b1100, 0, 1, "R3 shl fill 1");
    // R8 fills tied for sign-keeping and rotates
    drive(8'h96, 8'h00, 0, 4'b1000, 1, 0, "R8 arithmetic shr negative");
    drive(8'h46, 8'h00, 0, 4'b1000, 0, 0, "R8 arithmetic shr positive");
    drive(8'h81, 8'h00, 0, 4'b1000, 1, 0, "R8 rotate right");
    drive(8'h81, 8'h00, 0, 4'b1100, 0, 1, "R8 rotate left");
    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule